// File: doc/BRIEF.md
# Auto-Reload Timer Baud Tick Generator

This block makes the bit-rate strobe for the variable-rate serial modes of a UART. An 8-bit up-counter advances once every two peripheral clocks. When it passes its top value it takes a programmable reload byte and emits a one-cycle overflow pulse. A 5-bit stage divides those pulses by 32, or by 16 when the double-rate select is set. The resulting tick rate is fPCLK × 2^dbl / (64 × (256 − reload)). A 16x oversampling strobe for the receiver is taken from the same chain and lines up with the bit tick.

The ÷2 prescale is a two-state machine. PH_FIRST moves to PH_SECOND on a clock with `run_en` high. PH_SECOND moves back to PH_FIRST on a clock with `run_en` high. With `run_en` low, either state holds. The timer advances only when PH_SECOND is left. The rate divider counts overflows only while `var_mode` says a variable-rate serial mode is selected. The timer itself keeps overflowing either way.

Top module: `tmr_baud_gen`

## Requirements
- R1: A synchronous reset clears the prescale state to PH_FIRST, the timer to 0 and the rate divider to 0, and holds all three outputs low. With `run_en` high from the first clock after reset, `tmr_ovf` first goes high in the 512th cycle.
- R2: The timer advances once per two enabled clocks. `tmr_ovf` is high for exactly one cycle when the timer advances from 0xFF. After the first overflow, overflows are spaced 2 × (256 − reload) cycles apart.
- R3: On an overflow the timer loads the value present on `reload_val` at that clock edge. A change of `reload_val` between overflows affects only the period that starts at the next overflow.
- R4: With `dbl_rate` low and `var_mode` high, `baud_tick` pulses on every 32nd overflow, which is every 64 × (256 − reload) cycles.
- R5: With `dbl_rate` high and `var_mode` high, `baud_tick` pulses on every 16th overflow, which is every 32 × (256 − reload) cycles.
- R6: With `dbl_rate` high, `os_tick` pulses on every overflow. With `dbl_rate` low, it pulses on every second overflow, namely those where the divider count is odd. In both cases exactly 16 `os_tick` pulses fall in each bit period, and the last one coincides with `baud_tick`.
- R7: While `var_mode` is low, `baud_tick` and `os_tick` stay low and the rate divider holds its count. `tmr_ovf` keeps pulsing at the rate given in R2.
- R8: While `run_en` is low, the prescale state, the timer and the divider all hold, and no output pulses. A pause of k cycles lengthens the current overflow period by exactly k cycles.
- R9: A reload value of 0xFF gives the highest rate: one overflow every 2 cycles.
- R10: The divider wraps when its count is at or above the terminal count (31, or 15 with `dbl_rate` high). So if `dbl_rate` is set while the count is above 15, the next overflow produces `baud_tick` and restarts the count at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Timer run enable; low freezes all counting |
| reload_val | input | 8 | Auto-reload byte loaded on overflow |
| dbl_rate | input | 1 | Double-rate select; halves the final divider |
| var_mode | input | 1 | High when a variable-rate serial mode is selected |
| baud_tick | output | 1 | One-cycle bit-rate strobe |
| os_tick | output | 1 | One-cycle 16x oversampling strobe |
| tmr_ovf | output | 1 | One-cycle timer overflow pulse |

## Verification
Overflow spacing is measured with reload bytes 0xF0, 0xE0 and 0xFF. This separates a counter that advances every clock from one that advances every second clock, and it shows whether a reload change takes effect one period late. Bit-tick spacing and the oversampling count per bit are measured with the double-rate select both low and high. This exposes a wrong terminal count or a misaligned oversampling tick. Pausing `run_en` and dropping `var_mode` in the middle of a period shows whether state is frozen or lost. Setting double rate while the divider count is above 15 checks the wrap rule.

// File: rtl/bg_pkg.sv
package bg_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } bg_phase_e;

    localparam int unsigned BG_CNT_W = 8;
    localparam int unsigned BG_DIV_W = 5;

endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler
    import bg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic step_o
);

    bg_phase_e state_q;
    bg_phase_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: toggle only while running
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FIRST:  if (run_en) state_d = PH_SECOND;
            PH_SECOND: if (run_en) state_d = PH_FIRST;
            default:   state_d = PH_FIRST;
        endcase
    end

    // outputs: timer advances when PH_SECOND is left
    always_comb begin
        step_o = 1'b0;
        unique case (state_q)
            PH_FIRST:  step_o = 1'b0;
            PH_SECOND: step_o = run_en;
            default:   step_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bg_reload_timer.sv
module bg_reload_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             ovf_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             at_top;

    assign at_top = (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (at_top) begin
                cnt_q <= reload_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        ovf_o = step_i & at_top;
        cnt_o = cnt_q;
    end

endmodule

// File: rtl/bg_rate_divider.sv
module bg_rate_divider #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ovf_i,
    input  logic             gate_i,
    input  logic             dbl_i,
    output logic             baud_o,
    output logic             os_o,
    output logic [DIV_W-1:0] div_o
);

    localparam logic [DIV_W-1:0] TERM_SLOW = '1;
    localparam logic [DIV_W-1:0] TERM_FAST = {1'b0, {(DIV_W-1){1'b1}}};

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] term;
    logic             adv;
    logic             wrap;

    always_comb begin
        term = dbl_i ? TERM_FAST : TERM_SLOW;
        adv  = ovf_i & gate_i;
        wrap = (div_q >= term);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (adv) begin
            if (wrap) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    always_comb begin
        baud_o = adv & wrap;
        os_o   = adv & (dbl_i | div_q[0]);
        div_o  = div_q;
    end

endmodule

// File: rtl/tmr_baud_gen.sv
module tmr_baud_gen
    import bg_pkg::*;
#(
    parameter int unsigned CNT_W = BG_CNT_W,
    parameter int unsigned DIV_W = BG_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             dbl_rate,
    input  logic             var_mode,
    output logic             baud_tick,
    output logic             os_tick,
    output logic             tmr_ovf
);

    logic             step;
    logic [CNT_W-1:0] tmr_cnt;
    logic [DIV_W-1:0] div_cnt;

    bg_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .step_o (step)
    );

    bg_reload_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .reload_i (reload_val),
        .ovf_o    (tmr_ovf),
        .cnt_o    (tmr_cnt)
    );

    bg_rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .ovf_i  (tmr_ovf),
        .gate_i (var_mode),
        .dbl_i  (dbl_rate),
        .baud_o (baud_tick),
        .os_o   (os_tick),
        .div_o  (div_cnt)
    );

endmodule

// File: rtl/tmr_baud_gen_chk.sv
module tmr_baud_gen_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DIV_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic [CNT_W-1:0] reload_val,
    input logic             var_mode,
    input logic             baud_tick,
    input logic             os_tick,
    input logic             tmr_ovf,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [DIV_W-1:0] div_cnt
);

    // R2: overflow never lasts two cycles
    a_r2_ovf_single: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> !tmr_ovf);

    // R3: timer holds the reload byte after an overflow
    a_r3_reload_load: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> (tmr_cnt == $past(reload_val)));

    // R4: a bit tick only comes with an overflow
    a_r4_baud_needs_ovf: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> tmr_ovf);

    // R6: last oversampling strobe of a bit coincides with the bit tick
    a_r6_os_with_baud: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> os_tick);

    // R7: no strobes and a frozen divider outside variable-rate modes
    a_r7_no_tick_novar: assert property (@(posedge clk) disable iff (rst)
        !var_mode |-> (!baud_tick && !os_tick));
    a_r7_div_hold: assert property (@(posedge clk) disable iff (rst)
        !var_mode |=> $stable(div_cnt));

    // R8: stopped timer produces nothing and keeps its counts
    a_r8_no_ovf_idle: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !tmr_ovf);
    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> ($stable(tmr_cnt) && $stable(div_cnt)));

endmodule

bind tmr_baud_gen tmr_baud_gen_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .reload_val (reload_val),
    .var_mode   (var_mode),
    .baud_tick  (baud_tick),
    .os_tick    (os_tick),
    .tmr_ovf    (tmr_ovf),
    .tmr_cnt    (tmr_cnt),
    .div_cnt    (div_cnt)
);

// File: tb/test_tmr_baud_gen.sv
module test_tmr_baud_gen;

    localparam time TCLK = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b1;
    logic [7:0] reload_val = 8'hF0;
    logic       dbl_rate = 1'b0;
    logic       var_mode = 1'b1;
    logic       baud_tick;
    logic       os_tick;
    logic       tmr_ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(TCLK/2) clk = ~clk;

    tmr_baud_gen i_tmr_baud_gen (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .reload_val (reload_val),
        .dbl_rate   (dbl_rate),
        .var_mode   (var_mode),
        .baud_tick  (baud_tick),
        .os_tick    (os_tick),
        .tmr_ovf    (tmr_ovf)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: half-rate counting, overflow tally per bit
    int m_half  = 0;
    int m_value = 0;
    int m_tally = 0;

    function automatic int m_limit();
        return dbl_rate ? 16 : 32;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_half = 0; m_value = 0; m_tally = 0;
        end else if (run_en) begin
            if (m_half == 1) begin
                if (m_value == 255) begin
                    m_value = reload_val;
                    if (var_mode) begin
                        if (m_tally + 1 >= m_limit()) m_tally = 0;
                        else m_tally = m_tally + 1;
                    end
                end else begin
                    m_value = m_value + 1;
                end
            end
            m_half = 1 - m_half;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_ovf, e_baud, e_os;
            e_ovf  = run_en && (m_half == 1) && (m_value == 255);
            e_baud = e_ovf && var_mode && (m_tally + 1 >= m_limit());
            e_os   = e_ovf && var_mode && (dbl_rate || (m_tally % 2 == 1));
            check("R2 overflow", int'(tmr_ovf), int'(e_ovf));
            check(dbl_rate ? "R5 bit tick" : "R4 bit tick", int'(baud_tick), int'(e_baud));
            check("R6 oversample", int'(os_tick), int'(e_os));
        end
    end

    task automatic step_cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cycles_to_ovf(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tmr_ovf);
    endtask

    task automatic cycles_to_baud(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!baud_tick);
    endtask

    task automatic os_per_bit(output int k);
        k = 0;
        do begin @(negedge clk); k += int'(os_tick); end while (!baud_tick);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(TCLK * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int acc;
        step_cycles(3);
        @(negedge clk);
        check("R1 reset ovf", int'(tmr_ovf), 0);
        check("R1 reset baud", int'(baud_tick), 0);
        check("R1 reset os", int'(os_tick), 0);
        step_cycles(1);
        rst = 1'b0;
        cycles_to_ovf(n);
        check("R1 first overflow cycle", n, 512);

        // R2: reload 0xF0 -> 32 cycles
        cycles_to_ovf(n);
        check("R2 period F0", n, 32);

        // R3: change reload right after an overflow
        step_cycles(1);
        reload_val = 8'hE0;
        cycles_to_ovf(n);
        check("R3 old reload kept", n, 32);
        cycles_to_ovf(n);
        check("R3 new reload used", n, 64);

        // R9: reload 0xFF
        step_cycles(1);
        reload_val = 8'hFF;
        cycles_to_ovf(n);
        check("R9 transition period", n, 64);
        cycles_to_ovf(n);
        check("R9 max rate", n, 2);

        // R4 / R6 slow mode
        do @(negedge clk); while (!baud_tick);
        cycles_to_baud(n);
        check("R4 bit period", n, 64);
        os_per_bit(acc);
        check("R6 os per bit slow", acc, 16);

        // R5 / R6 double rate
        step_cycles(1);
        dbl_rate = 1'b1;
        cycles_to_baud(n);
        check("R5 bit period", n, 32);
        os_per_bit(acc);
        check("R6 os per bit fast", acc, 16);

        // R7: leave variable-rate mode
        step_cycles(1);
        var_mode = 1'b0;
        acc = 0; n = 0;
        begin
            int b = 0;
            repeat (200) begin
                @(negedge clk);
                acc += int'(tmr_ovf);
                b += int'(baud_tick) + int'(os_tick);
            end
            check("R7 strobes suppressed", b, 0);
            check("R7 overflow continues", acc, 100);
        end
        step_cycles(1);
        var_mode = 1'b1;
        cycles_to_baud(n);
        check("R7 divider held", n, 32);

        // R8: pause mid-period with reload 0xF0
        step_cycles(1);
        reload_val = 8'hF0;
        dbl_rate = 1'b0;
        cycles_to_ovf(n);
        cycles_to_ovf(n);
        check("R8 period before pause", n, 32);
        step_cycles(1);
        run_en = 1'b0;
        acc = 0;
        repeat (50) begin
            @(negedge clk);
            acc += int'(tmr_ovf) + int'(baud_tick) + int'(os_tick);
        end
        check("R8 silent when stopped", acc, 0);
        step_cycles(1);
        run_en = 1'b1;
        cycles_to_ovf(n);
        check("R8 period stretched", n + 50, 82);

        // R10: enable double rate with the divider above 15
        step_cycles(1);
        reload_val = 8'hFF;
        cycles_to_ovf(n);
        cycles_to_ovf(n);
        do @(negedge clk); while (!baud_tick);
        repeat (20) begin
            do @(negedge clk); while (!tmr_ovf);
        end
        step_cycles(1);
        dbl_rate = 1'b1;
        do @(negedge clk); while (!tmr_ovf);
        check("R10 wrap above terminal", int'(baud_tick), 1);
        cycles_to_baud(n);
        check("R10 restart at zero", n, 32);

        step_cycles(2);
        finish_run();
    end

endmodule